// File: doc/BRIEF.md
# Vector-Indexed Gather Operand Decoder

This block turns the addressing bytes of a vector-indexed gather instruction into a decoded operand bundle. A front end pulses `start` and supplies the prefix-derived context for the instruction. The context is the register-extension bits, the mask register number, the vector and element width flags, the index width chosen by the opcode, the segment-override flag, the default segment and the address and operand modes. The decoder captures this context on the `start` cycle. It then takes the addressing-mode byte, the scale/index/base byte and any displacement bytes one at a time over a valid/ready handshake, and stalls whenever no byte is offered.

The gather form only allows a memory operand that carries a scale/index/base byte. Any other form ends decoding at once with an invalid-opcode pulse. On success the decoder emits a one-cycle `done` pulse. The bundle then holds the destination, index and mask vector register numbers, the base general register, the scale code, the effective segment, the width flags, the two modes and the 32-bit displacement. If the destination, index and mask registers are not all distinct, the decoder rejects the instruction instead of completing it.

Top module: `gather_addr_decoder`

## Requirements
- R1: If the first addressing byte has bits 7:6 = 3 (register form), `ud` pulses in the cycle after that byte is accepted, `byte_ready` is low in that cycle, and no further byte is taken.
- R2: If the first addressing byte has bits 2:0 other than 4 (no scale/index/base byte follows), `ud` pulses in the cycle after that byte is accepted, and no further byte is taken.
- R3: The displacement depends on first-byte bits 7:6. A value of 0 gives zero and no bytes. A value of 1 takes one byte, sign-extended to 32 bits. A value of 2 takes four bytes, least significant first. `done` or `ud` follows in the cycle after the last addressing byte is accepted.
- R4: The register numbers and scale code are formed as follows, with first byte M and second byte S:
  - destination = {ext_r, M[5:3]}
  - index = {ext_x, S[5:3]}
  - base = {ext_b, S[2:0]}
  - mask = `mask_sel` (already a plain register number)
  - scale = S[7:6]
- R5: If the full 4-bit base number is 4 or 5 and `seg_ovr` is low, `eff_seg` is 2 (the stack segment code). In every other case `eff_seg` equals `dflt_seg`. Base numbers 12 and 13 therefore keep the default segment.
- R6: `vec256`, `elem64`, `idx64`, `addr_mode_o` and `op_mode_o` report `wide_vec`, `wide_elem`, `idx_wide`, `addr_mode` and `op_mode`. All context inputs are sampled only on the cycle `start` is accepted, so later changes have no effect on the result.
- R7: If any two of destination, index and mask are equal, `ud` pulses in place of `done`. This happens in the cycle after the last addressing byte.
- R8: `done` and `ud` are never high together, and each lasts one cycle. The decoder is idle in that cycle and accepts a new `start` there.
- R9: A byte is consumed only when `byte_valid` and `byte_ready` are both high. `byte_ready` is high exactly while an instruction is being decoded. Bytes offered while idle, and `start` raised while busy, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin decoding; context sampled when accepted in idle |
| idx_wide | input | 1 | Opcode selects 64-bit indices |
| ext_r | input | 1 | Extension bit 3 for destination register |
| ext_x | input | 1 | Extension bit 3 for index register |
| ext_b | input | 1 | Extension bit 3 for base register |
| wide_vec | input | 1 | 256-bit vector length |
| wide_elem | input | 1 | 64-bit elements |
| mask_sel | input | 4 | Mask vector register number |
| seg_ovr | input | 1 | Segment-override prefix present |
| dflt_seg | input | 3 | Default segment code |
| addr_mode | input | 2 | Address mode |
| op_mode | input | 2 | Operand mode |
| byte_valid | input | 1 | Addressing byte offered |
| byte_data | input | 8 | Addressing byte |
| byte_ready | output | 1 | Decoder accepts a byte |
| done | output | 1 | Decode completed, bundle valid |
| ud | output | 1 | Invalid-opcode pulse |
| dst_reg | output | 4 | Destination vector register |
| idx_reg | output | 4 | Index vector register |
| msk_reg | output | 4 | Mask vector register |
| base_reg | output | 4 | Base general register |
| scale | output | 2 | Scale code (x1, x2, x4, x8) |
| eff_seg | output | 3 | Effective segment |
| addr_mode_o | output | 2 | Captured address mode |
| op_mode_o | output | 2 | Captured operand mode |
| vec256 | output | 1 | Captured vector width flag |
| idx64 | output | 1 | Captured index width flag |
| elem64 | output | 1 | Captured element width flag |
| disp | output | 32 | Displacement |

## Verification
Two things can share a cycle. The first is the completion pulse, either `done` or `ud`. The second is the acceptance of the next `start`. The bench provokes this by raising `start` in exactly the cycle the previous pulse is high, and by holding scrambled context inputs during decoding. A reference model that follows each byte with integers then judges three things every cycle: that the new decode begins on time, that the pulse is not repeated, and that the finished bundle reflects only the context captured at its own `start`. A second same-cycle case occurs when a register-register conflict and the final displacement byte arrive together. The bench judges it by expecting `ud`, and not `done`, in that byte's following cycle.

// File: rtl/gad_pkg.sv
package gad_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MODE  = 2'd1,
    ST_SIB   = 2'd2,
    ST_DISP  = 2'd3
  } gad_state_t;

  localparam logic [1:0] MOD_NODISP = 2'd0;
  localparam logic [1:0] MOD_DISP8  = 2'd1;
  localparam logic [1:0] MOD_REG    = 2'd3;
  localparam logic [2:0] RM_HAS_SIB = 3'd4;
endpackage

// File: rtl/gad_fields.sv
module gad_fields #(
  parameter int RW = 4,
  parameter int SW = 3,
  parameter logic [SW-1:0] STACK_SEG = 3'd2
) (
  input  logic [7:0]    mode_byte,
  input  logic [7:0]    sib_byte,
  input  logic          ext_r,
  input  logic          ext_x,
  input  logic          ext_b,
  input  logic          seg_ovr,
  input  logic [SW-1:0] dflt_seg,
  output logic [RW-1:0] dst,
  output logic [RW-1:0] idx,
  output logic [RW-1:0] base,
  output logic [1:0]    scale,
  output logic [SW-1:0] seg
);
  always_comb begin
    dst   = RW'({ext_r, mode_byte[5:3]});
    idx   = RW'({ext_x, sib_byte[5:3]});
    base  = RW'({ext_b, sib_byte[2:0]});
    scale = sib_byte[7:6];
    if (((base == RW'(4)) || (base == RW'(5))) && !seg_ovr)
      seg = STACK_SEG;
    else
      seg = dflt_seg;
  end
endmodule

// File: rtl/gad_dup_check.sv
module gad_dup_check #(
  parameter int N = 3,
  parameter int W = 4
) (
  input  logic [N-1:0][W-1:0] regs,
  output logic                dup
);
  logic [N*N-1:0] eq;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (j > i) begin : g_cmp
        assign eq[i*N+j] = (regs[i] == regs[j]);
      end else begin : g_none
        assign eq[i*N+j] = 1'b0;
      end
    end
  end

  assign dup = |eq;
endmodule

// File: rtl/gad_disp_collect.sv
module gad_disp_collect #(
  parameter int NB = 4,
  localparam int PW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          load,
  input  logic          sext,
  input  logic [7:0]    byte_in,
  output logic [NB*8-1:0] disp_o
);
  logic [PW-1:0] pos_q;
  logic [7:0]    lane_q [NB];

  always_ff @(posedge clk) begin
    if (rst || clear)
      pos_q <= '0;
    else if (load)
      pos_q <= pos_q + PW'(1);
  end

  for (genvar k = 0; k < NB; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        lane_q[k] <= 8'h00;
      end else if (load) begin
        if (sext)
          lane_q[k] <= (k == 0) ? byte_in : {8{byte_in[7]}};
        else if (pos_q == PW'(k))
          lane_q[k] <= byte_in;
      end
    end
    assign disp_o[k*8 +: 8] = lane_q[k];
  end
endmodule

// File: rtl/gather_addr_decoder.sv
module gather_addr_decoder
  import gad_pkg::*;
#(
  parameter int RW = 4,
  parameter int SW = 3,
  parameter int MW = 2,
  parameter int DISP_BYTES = 4,
  parameter logic [SW-1:0] STACK_SEG = 3'd2,
  localparam int DW = DISP_BYTES * 8,
  localparam int CW = $clog2(DISP_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          idx_wide,
  input  logic          ext_r,
  input  logic          ext_x,
  input  logic          ext_b,
  input  logic          wide_vec,
  input  logic          wide_elem,
  input  logic [RW-1:0] mask_sel,
  input  logic          seg_ovr,
  input  logic [SW-1:0] dflt_seg,
  input  logic [MW-1:0] addr_mode,
  input  logic [MW-1:0] op_mode,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  output logic          byte_ready,
  output logic          done,
  output logic          ud,
  output logic [RW-1:0] dst_reg,
  output logic [RW-1:0] idx_reg,
  output logic [RW-1:0] msk_reg,
  output logic [RW-1:0] base_reg,
  output logic [1:0]    scale,
  output logic [SW-1:0] eff_seg,
  output logic [MW-1:0] addr_mode_o,
  output logic [MW-1:0] op_mode_o,
  output logic          vec256,
  output logic          idx64,
  output logic          elem64,
  output logic [DW-1:0] disp
);
  gad_state_t    st_q;
  logic [7:0]    mode_q;
  logic [CW-1:0] rem_q;
  logic          conf_q;
  logic          c_ext_r, c_ext_x, c_ext_b, c_seg_ovr;
  logic [SW-1:0] c_dseg;

  logic          acc;
  logic [RW-1:0] f_dst, f_idx, f_base;
  logic [1:0]    f_scale;
  logic [SW-1:0] f_seg;
  logic          conf_now;
  logic [2:0][RW-1:0] chk_regs;

  assign byte_ready = (st_q != ST_IDLE);
  assign acc        = byte_valid && byte_ready;

  gad_fields #(.RW(RW), .SW(SW), .STACK_SEG(STACK_SEG)) u_fields (
    .mode_byte (mode_q),
    .sib_byte  (byte_data),
    .ext_r     (c_ext_r),
    .ext_x     (c_ext_x),
    .ext_b     (c_ext_b),
    .seg_ovr   (c_seg_ovr),
    .dflt_seg  (c_dseg),
    .dst       (f_dst),
    .idx       (f_idx),
    .base      (f_base),
    .scale     (f_scale),
    .seg       (f_seg)
  );

  assign chk_regs = {f_dst, f_idx, msk_reg};

  gad_dup_check #(.N(3), .W(RW)) u_dup (
    .regs (chk_regs),
    .dup  (conf_now)
  );

  gad_disp_collect #(.NB(DISP_BYTES)) u_disp (
    .clk     (clk),
    .rst     (rst),
    .clear   ((st_q == ST_MODE) && acc),
    .load    ((st_q == ST_DISP) && acc),
    .sext    (mode_q[7:6] == MOD_DISP8),
    .byte_in (byte_data),
    .disp_o  (disp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      done        <= 1'b0;
      ud          <= 1'b0;
      mode_q      <= 8'h00;
      rem_q       <= '0;
      conf_q      <= 1'b0;
      c_ext_r     <= 1'b0;
      c_ext_x     <= 1'b0;
      c_ext_b     <= 1'b0;
      c_seg_ovr   <= 1'b0;
      c_dseg      <= '0;
      dst_reg     <= '0;
      idx_reg     <= '0;
      msk_reg     <= '0;
      base_reg    <= '0;
      scale       <= '0;
      eff_seg     <= '0;
      addr_mode_o <= '0;
      op_mode_o   <= '0;
      vec256      <= 1'b0;
      idx64       <= 1'b0;
      elem64      <= 1'b0;
    end else begin
      done <= 1'b0;
      ud   <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            c_ext_r     <= ext_r;
            c_ext_x     <= ext_x;
            c_ext_b     <= ext_b;
            c_seg_ovr   <= seg_ovr;
            c_dseg      <= dflt_seg;
            msk_reg     <= mask_sel;
            addr_mode_o <= addr_mode;
            op_mode_o   <= op_mode;
            vec256      <= wide_vec;
            idx64       <= idx_wide;
            elem64      <= wide_elem;
            st_q        <= ST_MODE;
          end
        end
        ST_MODE: begin
          if (acc) begin
            mode_q <= byte_data;
            if ((byte_data[7:6] == MOD_REG) || (byte_data[2:0] != RM_HAS_SIB)) begin
              ud   <= 1'b1;
              st_q <= ST_IDLE;
            end else begin
              st_q <= ST_SIB;
            end
          end
        end
        ST_SIB: begin
          if (acc) begin
            dst_reg  <= f_dst;
            idx_reg  <= f_idx;
            base_reg <= f_base;
            scale    <= f_scale;
            eff_seg  <= f_seg;
            conf_q   <= conf_now;
            if (mode_q[7:6] == MOD_NODISP) begin
              done <= !conf_now;
              ud   <= conf_now;
              st_q <= ST_IDLE;
            end else begin
              rem_q <= (mode_q[7:6] == MOD_DISP8) ? CW'(1) : CW'(DISP_BYTES);
              st_q  <= ST_DISP;
            end
          end
        end
        default: begin
          if (acc) begin
            rem_q <= rem_q - CW'(1);
            if (rem_q == CW'(1)) begin
              done <= !conf_q;
              ud   <= conf_q;
              st_q <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end

  // R8
  excl_pulse_chk: assert property (@(posedge clk) disable iff (rst) !(done && ud));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R8
  ud_single_chk: assert property (@(posedge clk) disable iff (rst) ud |=> !ud);
  // R1
  regform_ud_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_MODE && byte_valid && byte_data[7:6] == MOD_REG) |=> (ud && !byte_ready));
  // R7
  done_distinct_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (dst_reg != idx_reg && idx_reg != msk_reg && dst_reg != msk_reg));
  // R5
  stack_seg_chk: assert property (@(posedge clk) disable iff (rst)
    (done && (base_reg == RW'(4) || base_reg == RW'(5)) && !c_seg_ovr) |-> (eff_seg == STACK_SEG));
  // R9
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (done || ud) |-> !byte_ready);
endmodule

// File: tb/tb_gather_addr_decoder.sv
module tb_gather_addr_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, idx_wide = 1'b0, ext_r = 1'b0, ext_x = 1'b0, ext_b = 1'b0;
  logic wide_vec = 1'b0, wide_elem = 1'b0, seg_ovr = 1'b0;
  logic [3:0] mask_sel = 4'h0;
  logic [2:0] dflt_seg = 3'd0;
  logic [1:0] addr_mode = 2'd0, op_mode = 2'd0;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic byte_ready, done, ud, vec256, idx64, elem64;
  logic [3:0] dst_reg, idx_reg, msk_reg, base_reg;
  logic [1:0] scale, addr_mode_o, op_mode_o;
  logic [2:0] eff_seg;
  logic [31:0] disp;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  gather_addr_decoder dut (
    .clk(clk), .rst(rst), .start(start), .idx_wide(idx_wide),
    .ext_r(ext_r), .ext_x(ext_x), .ext_b(ext_b),
    .wide_vec(wide_vec), .wide_elem(wide_elem), .mask_sel(mask_sel),
    .seg_ovr(seg_ovr), .dflt_seg(dflt_seg), .addr_mode(addr_mode), .op_mode(op_mode),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
    .done(done), .ud(ud), .dst_reg(dst_reg), .idx_reg(idx_reg), .msk_reg(msk_reg),
    .base_reg(base_reg), .scale(scale), .eff_seg(eff_seg),
    .addr_mode_o(addr_mode_o), .op_mode_o(op_mode_o),
    .vec256(vec256), .idx64(idx64), .elem64(elem64), .disp(disp)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference model
  int m_st, m_mod, m_reg, m_left, m_nb;
  bit m_done, m_ud, m_conf;
  bit cr, cx, cb, cl, cw, ci, cso;
  int cm, cds, cam, com;
  int e_dst, e_idx, e_base, e_scale, e_seg;
  logic [31:0] e_disp;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_st = 0; m_done = 0; m_ud = 0;
    end else begin
      m_done = 0; m_ud = 0;
      if (m_st == 0) begin
        if (start) begin
          cr = ext_r; cx = ext_x; cb = ext_b; cl = wide_vec; cw = wide_elem; ci = idx_wide;
          cso = seg_ovr; cm = mask_sel; cds = dflt_seg; cam = addr_mode; com = op_mode;
          m_st = 1;
        end
      end else if (byte_valid) begin
        if (m_st == 1) begin
          if (byte_data[7:6] == 2'd3 || byte_data[2:0] != 3'd4) begin
            m_ud = 1; m_st = 0;
          end else begin
            m_mod = int'(byte_data[7:6]); m_reg = int'(byte_data[5:3]); m_st = 2;
          end
        end else if (m_st == 2) begin
          e_dst = (cr ? 8 : 0) + m_reg;
          e_idx = (cx ? 8 : 0) + int'(byte_data[5:3]);
          e_base = (cb ? 8 : 0) + int'(byte_data[2:0]);
          e_scale = int'(byte_data[7:6]);
          e_seg = ((e_base == 4 || e_base == 5) && !cso) ? 2 : cds;
          e_disp = 32'h0;
          m_conf = (e_dst == e_idx) || (e_idx == cm) || (e_dst == cm);
          if (m_mod == 0) begin
            if (m_conf) m_ud = 1; else m_done = 1;
            m_st = 0;
          end else begin
            m_left = (m_mod == 1) ? 1 : 4; m_nb = 0; m_st = 3;
          end
        end else begin
          if (m_mod == 1) e_disp = {{24{byte_data[7]}}, byte_data};
          else e_disp[m_nb*8 +: 8] = byte_data;
          m_nb++; m_left--;
          if (m_left == 0) begin
            if (m_conf) m_ud = 1; else m_done = 1;
            m_st = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R9 byte_ready", byte_ready, (m_st != 0));
      chk("R3 R7 R8 done", done, m_done);
      chk("R1 R2 R7 R8 ud", ud, m_ud);
      if (m_done) begin
        chk("R4 dst", dst_reg, e_dst);
        chk("R4 idx", idx_reg, e_idx);
        chk("R4 msk", msk_reg, cm);
        chk("R4 base", base_reg, e_base);
        chk("R4 scale", scale, e_scale);
        chk("R5 seg", eff_seg, e_seg);
        chk("R3 disp", disp, e_disp);
        chk("R6 flags", {vec256, idx64, elem64}, {cl, ci, cw});
        chk("R6 modes", {addr_mode_o, op_mode_o}, {cam[1:0], com[1:0]});
      end
    end
  end

  // Called at a negedge while the decoder is idle (or in a pulse cycle)
  task automatic begin_op(input bit r, x, b, l, w, i, input logic [3:0] m,
                          input bit so, input logic [2:0] ds, input logic [1:0] am, om);
    start = 1; ext_r = r; ext_x = x; ext_b = b; wide_vec = l; wide_elem = w; idx_wide = i;
    mask_sel = m; seg_ovr = so; dflt_seg = ds; addr_mode = am; op_mode = om;
    @(negedge clk);
    start = 0;
    // R6: scramble context while decoding; it must have no effect
    ext_r = ~r; ext_x = ~x; ext_b = ~b; wide_vec = ~l; wide_elem = ~w; idx_wide = ~i;
    mask_sel = ~m; seg_ovr = ~so; dflt_seg = ~ds; addr_mode = ~am; op_mode = ~om;
  endtask

  task automatic feed(input logic [7:0] bs[$], input int gap, input bit poke);
    foreach (bs[k]) begin
      if (!byte_ready) break;
      repeat (gap) begin
        byte_valid = 0;
        @(negedge clk);
      end
      byte_valid = 1; byte_data = bs[k];
      start = poke; // R9: start while busy is ignored
      @(negedge clk);
    end
    byte_valid = 0;
    start = 0;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R8 reset done", done, 0);
    chk("R8 reset ud", ud, 0);
    chk("R9 reset ready", byte_ready, 0);

    // R9: bytes offered while idle are ignored
    byte_valid = 1; byte_data = 8'h04;
    repeat (3) @(negedge clk);
    byte_valid = 0;

    // R5 R3: mod 0, base 4 without override -> stack segment, zero disp
    begin_op(0, 0, 0, 1, 0, 0, 4'd9, 0, 3'd3, 2'd2, 2'd1);
    feed('{8'b00_001_100, 8'b10_010_100}, 0, 0);
    @(negedge clk);
    // R3 R5: mod 1 negative disp8, base 5 with override -> default segment
    begin_op(1, 0, 0, 0, 1, 1, 4'd3, 1, 3'd5, 2'd1, 2'd2);
    feed('{8'b01_000_100, 8'b01_110_101, 8'h80}, 1, 0);
    // R3 R5 R8: back-to-back start in pulse cycle; mod 2, base 13 keeps default
    begin_op(0, 1, 1, 1, 1, 0, 4'd0, 0, 3'd4, 2'd0, 2'd0);
    feed('{8'b10_011_100, 8'b11_001_101, 8'h78, 8'h56, 8'h34, 8'h12}, 2, 1);
    // R1: register form
    begin_op(0, 0, 0, 0, 0, 0, 4'd1, 0, 3'd3, 2'd2, 2'd2);
    feed('{8'b11_010_100, 8'h00, 8'h00}, 0, 0);
    // R2: no scale/index/base byte
    begin_op(0, 0, 0, 0, 0, 0, 4'd1, 0, 3'd3, 2'd2, 2'd2);
    feed('{8'b00_010_101, 8'h00}, 0, 0);
    // R7: dst == idx, after disp8
    begin_op(0, 0, 0, 0, 0, 0, 4'd7, 0, 3'd3, 2'd2, 2'd2);
    feed('{8'b01_010_100, 8'b00_010_000, 8'h11}, 0, 0);
    // R7: idx == mask
    begin_op(0, 1, 0, 0, 0, 0, 4'd10, 0, 3'd3, 2'd2, 2'd2);
    feed('{8'b00_001_100, 8'b00_010_000}, 0, 0);
    // R7: dst == mask, after disp32
    begin_op(1, 0, 0, 0, 0, 0, 4'd14, 0, 3'd3, 2'd2, 2'd2);
    feed('{8'b10_110_100, 8'b00_000_000, 8'h01, 8'h02, 8'h03, 8'h04}, 1, 0);

    // Pseudo-random mix of all forms (R1..R9)
    for (int n = 0; n < 300; n++) begin
      logic [7:0] q[$];
      logic [7:0] mb;
      mb = 8'($urandom);
      if (($urandom % 5) != 0) mb[2:0] = 3'd4;
      q = '{mb, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom)};
      if (($urandom % 3) == 0) @(negedge clk);
      begin_op(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), 4'($urandom), 1'($urandom), 3'($urandom),
               2'($urandom), 2'($urandom));
      feed(q, int'($urandom % 3), 1'($urandom));
    end
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule